// File: doc/BRIEF.md
# Register-Composed Memory Address Unit

This block forms a 16-bit data memory address from two 8-bit index registers (X and Y) and the 8-bit immediate operand of the current instruction. It has no adder. Each half of the address is picked from a small set of sources. The high byte is either zero or Y. The low byte is either the operand or X. A 3-bit mode field makes the choice.

The same unit owns the X and Y registers. Two modes load X or Y from the result of the current operation. One mode reads through {Y, X} and then steps X by one. The step wraps inside X and never carries into Y. A jump leaves both registers untouched. The address is combinational on the current mode, operand and register values. Register updates take effect at the clock edge.

Top module: `mem_addr_unit`

## Requirements
- R1: While `rst_n` is low, X and Y are cleared to 0x00 at the clock edge, so `x_q` and `y_q` read 0x00 after reset.
- R2: The high byte `addr[15:8]` is 0x00 for modes 0, 1, 4, 5 and 6. It equals the current Y for modes 2, 3 and 7.
- R3: The low byte `addr[7:0]` equals `oper` for modes 0, 2, 4, 5 and 6. It equals the current X for modes 1, 3 and 7.
- R4: In mode 7 with `inc_en` high and `jump` low, X becomes X+1 modulo 256 at the clock edge, so 0xFF wraps to 0x00.
- R5: A mode-7 increment never changes Y, including when X wraps from 0xFF to 0x00.
- R6: With `ld_en` high and `jump` low, mode 4 loads X from `alu_res` and mode 5 loads Y from `alu_res` at the clock edge. The other register keeps its value.
- R7: While `jump` is high, X and Y keep their values whatever the mode, `ld_en` and `inc_en` are.
- R8: In modes 0 to 3 and 6, X and Y keep their values. The same holds in modes 4 and 5 with `ld_en` low, and in mode 7 with `inc_en` low.
- R9: `addr` follows the mode, the operand and the register values in the same cycle, with no register stage. An updated X or Y shows in `addr` right after the edge that writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Address/register mode field |
| oper | input | 8 | Immediate operand of the instruction |
| alu_res | input | 8 | Result of the current operation, load source for X and Y |
| ld_en | input | 1 | Enables the register load of modes 4 and 5 |
| inc_en | input | 1 | Enables the post-increment of mode 7 |
| jump | input | 1 | Current instruction is a jump; suppresses all register updates |
| addr | output | 16 | Composed memory address |
| x_q | output | 8 | Current X register |
| y_q | output | 8 | Current Y register |

## Verification
The address is due in the same cycle as its inputs. The bench drives each stimulus on the falling edge and checks `addr` one time step later, well before the next rising edge. Register effects such as loads, increments and holds are due one rising edge later. They are checked one time step after that edge, against a model of X and Y kept in the bench. The sweep covers all eight modes with many operand and register values, and every combination of `ld_en`, `inc_en` and `jump`. So each address check also sees the register state that earlier steps left behind.

// File: rtl/mem_addr_unit.sv
module mem_addr_unit #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic [BW-1:0] oper,
  input  logic [BW-1:0] alu_res,
  input  logic          ld_en,
  input  logic          inc_en,
  input  logic          jump,
  output logic [2*BW-1:0] addr,
  output logic [BW-1:0] x_q,
  output logic [BW-1:0] y_q
);
  logic hi_from_y, lo_from_x, x_load, y_load, x_step;

  assign hi_from_y = (mode == 3'd2) || (mode == 3'd3) || (mode == 3'd7);
  assign lo_from_x = (mode == 3'd1) || (mode == 3'd3) || (mode == 3'd7);

  assign addr = {hi_from_y ? y_q : {BW{1'b0}}, lo_from_x ? x_q : oper};

  assign x_load = !jump && ld_en  && (mode == 3'd4);
  assign y_load = !jump && ld_en  && (mode == 3'd5);
  assign x_step = !jump && inc_en && (mode == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      if (x_load)      x_q <= alu_res;
      else if (x_step) x_q <= x_q + 1'b1;
      if (y_load)      y_q <= alu_res;
    end
  end
endmodule

module mem_addr_unit_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode,
  input logic [BW-1:0] oper,
  input logic [BW-1:0] alu_res,
  input logic          ld_en,
  input logic          inc_en,
  input logic          jump,
  input logic [2*BW-1:0] addr,
  input logic [BW-1:0] x_q,
  input logic [BW-1:0] y_q
);
  AST_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode inside {3'd0, 3'd1, 3'd4, 3'd5, 3'd6}) |-> addr[2*BW-1:BW] == '0); // R2
  AST_HI_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (mode inside {3'd2, 3'd3, 3'd7}) |-> addr[2*BW-1:BW] == y_q); // R2
  AST_LO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    addr[BW-1:0] == ((mode inside {3'd1, 3'd3, 3'd7}) ? x_q : oper)); // R3
  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd7 && inc_en && !jump) |=> x_q == BW'($past(x_q) + 1'b1)); // R4
  AST_STEP_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd7 && !jump) |=> $stable(y_q)); // R5
  AST_X_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && ld_en && !jump) |=> x_q == $past(alu_res)); // R6
  AST_Y_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && ld_en && !jump) |=> y_q == $past(alu_res)); // R6
  AST_JUMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> ($stable(x_q) && $stable(y_q))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd6}) |=> ($stable(x_q) && $stable(y_q))); // R8
endmodule

bind mem_addr_unit mem_addr_unit_chk #(.BW(BW)) chk_i (.*);

// File: tb/mem_addr_unit_tb_top.sv
module mem_addr_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = '0;
  logic [7:0] oper = '0, alu_res = '0;
  logic ld_en = 1'b0, inc_en = 1'b0, jump = 1'b0;
  logic [15:0] addr;
  logic [7:0] x_q, y_q;

  int n_tests = 0, n_fail = 0;
  logic [7:0] mx = '0, my = '0;

  always #2.5 clk = ~clk;

  mem_addr_unit dut_i (.clk(clk), .rst_n(rst_n), .mode(mode), .oper(oper), .alu_res(alu_res),
    .ld_en(ld_en), .inc_en(inc_en), .jump(jump), .addr(addr), .x_q(x_q), .y_q(y_q));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] m, input logic [7:0] op, input logic [7:0] ar,
                      input logic ld, input logic inc, input logic jp);
    logic [15:0] ea;
    string rq;
    @(negedge clk);
    mode = m; oper = op; alu_res = ar; ld_en = ld; inc_en = inc; jump = jp;
    #1;
    ea[15:8] = (m == 3'd2 || m == 3'd3 || m == 3'd7) ? my : 8'h00;
    ea[7:0]  = (m == 3'd1 || m == 3'd3 || m == 3'd7) ? mx : op;
    check("R2/R3 address (R9 same cycle)", addr, ea);
    if (!jp) begin
      if (m == 3'd4 && ld) mx = ar;
      else if (m == 3'd7 && inc) mx = mx + 8'd1;
      if (m == 3'd5 && ld) my = ar;
    end
    rq = jp ? "R7 jump hold" : (m == 3'd7 && inc) ? "R4/R5 increment" :
         ((m == 3'd4 || m == 3'd5) && ld) ? "R6 load" : "R8 hold";
    @(posedge clk); #1;
    check(rq, {8'h00, x_q}, {8'h00, mx});
    check(rq, {8'h00, y_q}, {8'h00, my});
  endtask

  initial begin
    #20000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset X", {8'h00, x_q}, 16'h0000);
    check("R1 reset Y", {8'h00, y_q}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    // R5 wrap: X=FF, Y=12, increment -> X=00, Y=12
    step(3'd4, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b0);
    step(3'd5, 8'h00, 8'h12, 1'b1, 1'b0, 1'b0);
    step(3'd7, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R5 no carry Y", {8'h00, y_q}, 16'h0012);
    check("R4 wrap X", {8'h00, x_q}, 16'h0000);

    for (int xv = 0; xv < 256; xv += 17) begin
      for (int yv = 0; yv < 256; yv += 23) begin
        step(3'd4, 8'h00, 8'(xv), 1'b1, 1'b0, 1'b0);
        step(3'd5, 8'h00, 8'(yv), 1'b1, 1'b0, 1'b0);
        for (int m = 0; m < 8; m++) begin
          for (int c = 0; c < 8; c++) begin
            step(3'(m), 8'(xv * 7 + yv + c * 31), 8'(yv * 5 + c + 3),
                 c[0], c[1], c[2]);
          end
        end
      end
    end

    for (int i = 0; i < 300; i++) step(3'd7, 8'(i), 8'h00, 1'b0, 1'b1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule